// File: doc/BRIEF.md
# SDRAM Refresh and Low-Power Scheduler

This block sits beside the command scheduler of an SDRAM controller and keeps the memory refreshed on time. A free-running interval timer adds one owed auto-refresh to a saturating pending counter each period. While refreshes are owed, the block asks the main controller to close every bank. Once the controller reports that all banks are precharged and idle, the block takes the command bus, issues the auto-refresh command and holds NOP for the row-cycle time before it hands the bus back. Several owed refreshes are drained back to back, each spaced by the row-cycle time.

The block also drives the clock-enable pin. On request it puts the device into self-refresh, where it stops tracking refresh itself, or into power-down, where it does not. It leaves power-down as soon as a refresh becomes owed. After self-refresh exit it holds NOP for a full row cycle, and it restarts its interval timer. When the owed count reaches an urgency threshold, an urgent flag tells the main controller to stop opening rows, and refresh takes precedence over a pending self-refresh request.

Top module: `sdram_refresh_sched`

## Requirements
- R1: While reset is held and in the cycle after it, the command pins show NOP ({cs_n,ras_n,cas_n,we_n} = 0111), cke_o is 1, and busy_o, close_req_o and urgent_o are 0.
- R2: One refresh becomes owed every INTERVAL clock cycles, counted from reset release. close_req_o rises INTERVAL+1 cycles after reset release, and close_req_o is never high together with busy_o.
- R3: The auto-refresh command is {cs_n,ras_n,cas_n,we_n} = 0001 with cke_o = 1. It lasts one cycle and is issued only after bank_idle_i has been sampled high. While bank_idle_i stays low, only NOP appears.
- R4: Each auto-refresh is followed by NOP until T_RC cycles have passed since its command cycle. busy_o stays high for exactly T_RC cycles per refresh, and consecutive refreshes in a drain are exactly T_RC cycles apart.
- R5: The owed count saturates at MAX_PEND. After a long postponement, exactly MAX_PEND refreshes are issued back to back.
- R6: urgent_o is high exactly when the owed count is at least URGENT_LVL.
- R7: With sr_req_i high, banks idle and no urgent backlog, the block issues the self-refresh command ({cs_n,ras_n,cas_n,we_n} = 0001 with cke_o = 0). It then holds cke_o low with NOP and busy_o high for as long as sr_req_i stays high, and it issues no refresh during that time.
- R8: When sr_req_i falls, cke_o rises in the next cycle with NOP. busy_o stays high for exactly T_RC cycles counted from that cycle. Owed refreshes are discarded on entry, and the next refresh is issued INTERVAL+2 cycles after the cke_o rise.
- R9: With pd_req_i high, banks idle and nothing owed, cke_o goes low with NOP and busy_o high. When pd_req_i falls, cke_o rises for exactly one busy NOP cycle before the bus is released.
- R10: A refresh falling due during power-down forces exit. cke_o rises one cycle after the refresh becomes owed, and the refresh command follows three cycles after that rise.
- R11: When an urgent backlog and a self-refresh request are both present, refresh is served first until the backlog falls below URGENT_LVL, and self-refresh entry follows T_RC cycles after the last such refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_idle_i | input | 1 | All banks precharged and tRP satisfied, reported by the main controller |
| sr_req_i | input | 1 | Level request to enter and stay in self-refresh |
| pd_req_i | input | 1 | Level request to enter and stay in power-down |
| close_req_o | output | 1 | Asks the main controller to precharge all banks for a refresh |
| busy_o | output | 1 | Block owns the command bus; main controller must stay off it |
| urgent_o | output | 1 | Backlog at or above threshold; no new activates |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| cke_o | output | 1 | Clock enable to the device |

## Verification
The bench measures the first refresh to the exact cycle and drains a saturated backlog. A counter that wraps or saturates one too high would show the wrong refresh count, and a gap counter that is off by one would show spacing or busy lengths other than T_RC. Self-refresh is entered with refreshes already owed. A design that keeps that backlog, or that fails to restart its timer, issues a refresh earlier than INTERVAL+2 cycles after exit. Power-down is held across a refresh deadline, which catches a design that stays asleep or releases the bus without the exit cycle. An urgent backlog raced against a self-refresh request shows whether the priority order is right.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } sd_cmd_t;

   localparam sd_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
   localparam sd_cmd_t CMD_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CLOSE,
      ST_AREF,
      ST_GAP,
      ST_SR_ENTER,
      ST_SR_HOLD,
      ST_SR_EXIT,
      ST_PD_ENTER,
      ST_PD_HOLD,
      ST_PD_EXIT
   } rs_state_t;

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
   parameter int INTERVAL = 1560
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   output logic tick_o
);
   localparam int TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
   localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

   logic [TW-1:0] cnt_q;

   assign tick_o = (cnt_q == LAST) && !clr_i;

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         cnt_q <= '0;
      end else if (cnt_q == LAST) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/rfsh_pend_ctr.sv
module rfsh_pend_ctr #(
   parameter int MAX_PEND   = 8,
   parameter int URGENT_LVL = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc_i,
   input  logic dec_i,
   input  logic clr_i,
   output logic any_o,
   output logic urgent_o
);
   localparam int PW = $clog2(MAX_PEND + 1);
   localparam logic [PW-1:0] CAP = PW'(MAX_PEND);
   localparam logic [PW-1:0] URG = PW'(URGENT_LVL);

   logic [PW-1:0] cnt_q;
   logic          full;

   assign full     = (cnt_q == CAP);
   assign any_o    = (cnt_q != '0);
   assign urgent_o = (cnt_q >= URG);

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         cnt_q <= '0;
      end else begin
         unique case ({inc_i && !full, dec_i && any_o})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end
endmodule

// File: rtl/rfsh_gap_timer.sv
module rfsh_gap_timer #(
   parameter int T_RC = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic done_o
);
   localparam int GW = $clog2(T_RC);
   localparam logic [GW-1:0] START = GW'(T_RC - 2);

   logic [GW-1:0] cnt_q;

   assign done_o = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= START;
      end else if (!done_o) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/rfsh_cmd_drv.sv
module rfsh_cmd_drv
   import rfsh_pkg::*;
#(
   parameter bit REG_CMD = 1'b0
) (
   input  logic    clk,
   input  logic    rst_n,
   input  sd_cmd_t cmd_i,
   input  logic    cke_i,
   output logic    cs_n_o,
   output logic    ras_n_o,
   output logic    cas_n_o,
   output logic    we_n_o,
   output logic    cke_o
);
   sd_cmd_t pin_cmd;
   logic    pin_cke;

   generate
      if (REG_CMD) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pin_cmd <= CMD_NOP;
               pin_cke <= 1'b1;
            end else begin
               pin_cmd <= cmd_i;
               pin_cke <= cke_i;
            end
         end
      end else begin : g_comb
         assign pin_cmd = cmd_i;
         assign pin_cke = cke_i;
      end
   endgenerate

   assign cs_n_o  = pin_cmd.cs_n;
   assign ras_n_o = pin_cmd.ras_n;
   assign cas_n_o = pin_cmd.cas_n;
   assign we_n_o  = pin_cmd.we_n;
   assign cke_o   = pin_cke;
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
   import rfsh_pkg::*;
#(
   parameter int INTERVAL   = 1560,
   parameter int T_RC       = 7,
   parameter int MAX_PEND   = 8,
   parameter int URGENT_LVL = 4,
   parameter bit REG_CMD    = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bank_idle_i,
   input  logic sr_req_i,
   input  logic pd_req_i,
   output logic close_req_o,
   output logic busy_o,
   output logic urgent_o,
   output logic cs_n_o,
   output logic ras_n_o,
   output logic cas_n_o,
   output logic we_n_o,
   output logic cke_o
);
   generate
      if (INTERVAL < 2) begin : g_bad_interval
         $error("INTERVAL must be at least 2");
      end
      if (T_RC < 2) begin : g_bad_trc
         $error("T_RC must be at least 2");
      end
      if (MAX_PEND < 1) begin : g_bad_pend
         $error("MAX_PEND must be at least 1");
      end
      if (URGENT_LVL < 1 || URGENT_LVL > MAX_PEND) begin : g_bad_urg
         $error("URGENT_LVL must lie in 1..MAX_PEND");
      end
   endgenerate

   rs_state_t state_q, state_d;
   logic      tick, owed, urgent, gap_done;
   logic      tmr_clr, pend_clr, pend_dec, gap_load;
   sd_cmd_t   cmd;
   logic      cke;

   assign tmr_clr  = (state_q == ST_SR_ENTER) || (state_q == ST_SR_HOLD);
   assign pend_clr = (state_q == ST_SR_ENTER);
   assign pend_dec = (state_q == ST_AREF);
   assign gap_load = (state_q == ST_AREF) || (state_q == ST_SR_EXIT);

   rfsh_interval_timer #(.INTERVAL(INTERVAL)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (tmr_clr),
      .tick_o (tick)
   );

   rfsh_pend_ctr #(.MAX_PEND(MAX_PEND), .URGENT_LVL(URGENT_LVL)) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc_i    (tick),
      .dec_i    (pend_dec),
      .clr_i    (pend_clr),
      .any_o    (owed),
      .urgent_o (urgent)
   );

   rfsh_gap_timer #(.T_RC(T_RC)) u_gap (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (gap_load),
      .done_o (gap_done)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (urgent)                        state_d = ST_CLOSE;
            else if (sr_req_i && bank_idle_i)  state_d = ST_SR_ENTER;
            else if (owed)                     state_d = ST_CLOSE;
            else if (pd_req_i && bank_idle_i)  state_d = ST_PD_ENTER;
         end
         ST_CLOSE: begin
            if (bank_idle_i) state_d = (sr_req_i && !urgent) ? ST_SR_ENTER : ST_AREF;
         end
         ST_AREF: state_d = ST_GAP;
         ST_GAP: begin
            if (gap_done) begin
               if (owed && (urgent || !sr_req_i)) state_d = ST_AREF;
               else if (sr_req_i)                 state_d = ST_SR_ENTER;
               else                               state_d = ST_IDLE;
            end
         end
         ST_SR_ENTER: state_d = ST_SR_HOLD;
         ST_SR_HOLD:  if (!sr_req_i) state_d = ST_SR_EXIT;
         ST_SR_EXIT:  state_d = ST_GAP;
         ST_PD_ENTER: state_d = ST_PD_HOLD;
         ST_PD_HOLD:  if (!pd_req_i || owed) state_d = ST_PD_EXIT;
         ST_PD_EXIT:  state_d = ST_IDLE;
         default:     state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   always_comb begin
      cmd = CMD_NOP;
      cke = 1'b1;
      unique case (state_q)
         ST_AREF:     cmd = CMD_REF;
         ST_SR_ENTER: begin cmd = CMD_REF; cke = 1'b0; end
         ST_SR_HOLD,
         ST_PD_ENTER,
         ST_PD_HOLD:  cke = 1'b0;
         default:     ;
      endcase
   end

   assign close_req_o = (state_q == ST_CLOSE);
   assign busy_o      = (state_q != ST_IDLE) && (state_q != ST_CLOSE);
   assign urgent_o    = urgent;

   rfsh_cmd_drv #(.REG_CMD(REG_CMD)) u_drv (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd_i   (cmd),
      .cke_i   (cke),
      .cs_n_o  (cs_n_o),
      .ras_n_o (ras_n_o),
      .cas_n_o (cas_n_o),
      .we_n_o  (we_n_o),
      .cke_o   (cke_o)
   );
endmodule

// File: rtl/sdram_refresh_sched_chk.sv
module sdram_refresh_sched_chk #(
   parameter int T_RC = 7
) (
   input logic clk,
   input logic rst_n,
   input logic close_req_o,
   input logic busy_o,
   input logic urgent_o,
   input logic cs_n_o,
   input logic ras_n_o,
   input logic cas_n_o,
   input logic we_n_o,
   input logic cke_o
);
   localparam int SW = $clog2(T_RC + 1);

   logic          is_ref, is_self, is_nop;
   logic [SW-1:0] since_q;
   logic          in_sr_q;
   logic          cke_prev_q;

   assign is_nop  = {cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0111;
   assign is_ref  = cke_o  && ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0001);
   assign is_self = !cke_o && ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0001);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_q    <= SW'(T_RC);
         in_sr_q    <= 1'b0;
         cke_prev_q <= 1'b1;
      end else begin
         cke_prev_q <= cke_o;
         if (is_self) in_sr_q <= 1'b1;
         else if (cke_o && !cke_prev_q) in_sr_q <= 1'b0;
         if (is_ref || (cke_o && !cke_prev_q && in_sr_q)) since_q <= SW'(1);
         else if (since_q < SW'(T_RC)) since_q <= since_q + 1'b1;
      end
   end

   // R3: refresh command only with clock enabled and inside a bus grant
   p_ref_owned_r3: assert property (@(posedge clk) disable iff (!rst_n)
      is_ref |-> !close_req_o);

   // R4 and R8: row-cycle spacing after refresh and after self-refresh exit
   p_trc_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      is_ref |-> since_q >= SW'(T_RC));

   // R2: close request and bus ownership never overlap
   p_close_vs_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      close_req_o |-> !busy_o);

   // R7: while cke stays low only NOP is driven
   p_cke_low_nop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_o && !cke_prev_q) |-> is_nop);

   // R8: the cycle cke returns high carries NOP
   p_cke_rise_nop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cke_o && !cke_prev_q) |-> is_nop);

   // R11: no self-refresh entry while the backlog is urgent
   p_urgent_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
      is_self |-> !urgent_o);
endmodule

bind sdram_refresh_sched sdram_refresh_sched_chk #(.T_RC(T_RC)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .close_req_o (close_req_o),
   .busy_o      (busy_o),
   .urgent_o    (urgent_o),
   .cs_n_o      (cs_n_o),
   .ras_n_o     (ras_n_o),
   .cas_n_o     (cas_n_o),
   .we_n_o      (we_n_o),
   .cke_o       (cke_o)
);

// File: tb/sdram_refresh_sched_tb_top.sv
module sdram_refresh_sched_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int INTERVAL   = 100;
   localparam int T_RC       = 5;
   localparam int MAX_PEND   = 8;
   localparam int URGENT_LVL = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bank_idle_i = 1'b0;
   logic sr_req_i = 1'b0;
   logic pd_req_i = 1'b0;
   logic close_req_o, busy_o, urgent_o;
   logic cs_n_o, ras_n_o, cas_n_o, we_n_o, cke_o;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int base   = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   sdram_refresh_sched #(
      .INTERVAL(INTERVAL), .T_RC(T_RC), .MAX_PEND(MAX_PEND),
      .URGENT_LVL(URGENT_LVL), .REG_CMD(1'b0)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .bank_idle_i(bank_idle_i),
      .sr_req_i(sr_req_i), .pd_req_i(pd_req_i),
      .close_req_o(close_req_o), .busy_o(busy_o), .urgent_o(urgent_o),
      .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o),
      .we_n_o(we_n_o), .cke_o(cke_o)
   );

   function automatic logic [3:0] cmd_bits();
      return {cs_n_o, ras_n_o, cas_n_o, we_n_o};
   endfunction
   function automatic bit is_nop();
      return cmd_bits() == 4'b0111;
   endfunction
   function automatic bit is_ref();
      return cke_o && cmd_bits() == 4'b0001;
   endfunction
   function automatic bit is_self();
      return !cke_o && cmd_bits() == 4'b0001;
   endfunction
   function automatic int phase();
      return (cyc - base) % INTERVAL;
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wait_phase(input int p);
      do @(negedge clk); while (phase() != p);
   endtask

   task automatic wait_release();
      while (busy_o || close_req_o) @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1", "cmd in reset", int'(cmd_bits()), 4'b0111);
      chk("R1", "cke in reset", int'(cke_o), 1);
      chk("R1", "busy/close/urgent in reset", int'({busy_o, close_req_o, urgent_o}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "outputs after release",
          int'({cmd_bits(), cke_o, busy_o, close_req_o, urgent_o}), int'({4'b0111, 4'b1000}));
   endtask

   task automatic t_first_refresh();
      int n;
      while (!close_req_o) @(negedge clk);
      chk("R2", "close_req rise cycle", cyc, INTERVAL + 1);
      chk("R2", "busy during close", int'(busy_o), 0);
      n = 0;
      repeat (3) begin
         @(negedge clk);
         if (!is_nop()) n++;
      end
      chk("R3", "non-NOP while banks open", n, 0);
      bank_idle_i = 1'b1;
      @(negedge clk);
      chk("R3", "refresh command", int'({cmd_bits(), cke_o}), int'({4'b0001, 1'b1}));
      chk("R3", "busy at refresh", int'(busy_o), 1);
      n = 0;
      while (busy_o) begin
         n++;
         @(negedge clk);
         if (busy_o && !is_nop()) chk("R4", "NOP during gap", int'(cmd_bits()), 4'b0111);
      end
      chk("R4", "busy cycles per refresh", n, T_RC);
   endtask

   task automatic t_postpone();
      int n, last, bad;
      bank_idle_i = 1'b0;
      repeat (3) wait_phase(2);
      chk("R6", "urgent with 3 owed", int'(urgent_o), 0);
      wait_phase(2);
      chk("R6", "urgent with 4 owed", int'(urgent_o), 1);
      repeat (6) wait_phase(2);
      bank_idle_i = 1'b1;
      n = 0; last = 0; bad = 0;
      @(negedge clk);
      while (!busy_o) @(negedge clk);
      while (busy_o) begin
         if (is_ref()) begin
            if (n > 0 && cyc - last != T_RC) bad++;
            last = cyc;
            n++;
         end
         @(negedge clk);
      end
      chk("R5", "refreshes after saturation", n, MAX_PEND);
      chk("R4", "spacing violations in drain", bad, 0);
      chk("R6", "urgent after drain", int'(urgent_o), 0);
   endtask

   task automatic t_self_refresh();
      int bad, n;
      bank_idle_i = 1'b0;
      sr_req_i = 1'b1;
      repeat (2) wait_phase(2);
      bank_idle_i = 1'b1;
      @(negedge clk);
      chk("R7", "self-refresh entry", int'({cmd_bits(), cke_o, busy_o}), int'({4'b0001, 2'b01}));
      bad = 0;
      repeat (250) begin
         @(negedge clk);
         if (cke_o || !is_nop() || !busy_o || close_req_o) bad++;
      end
      chk("R7", "hold violations in self-refresh", bad, 0);
      sr_req_i = 1'b0;
      @(negedge clk);
      chk("R8", "exit cycle cke/NOP/busy", int'({cke_o, cmd_bits(), busy_o}), int'({1'b1, 4'b0111, 1'b1}));
      base = cyc;
      n = 0;
      while (busy_o) begin
         n++;
         @(negedge clk);
      end
      chk("R8", "busy cycles after exit", n, T_RC);
      while (!is_ref()) @(negedge clk);
      chk("R8", "first refresh after exit", cyc - base, INTERVAL + 2);
      @(negedge clk);
      wait_release();
   endtask

   task automatic t_priority();
      int nref, tref;
      bank_idle_i = 1'b0;
      repeat (4) wait_phase(5);
      chk("R11", "urgent before race", int'(urgent_o), 1);
      sr_req_i = 1'b1;
      bank_idle_i = 1'b1;
      nref = 0; tref = 0;
      @(negedge clk);
      while (!is_self()) begin
         if (is_ref()) begin
            nref++;
            tref = cyc;
         end
         @(negedge clk);
      end
      chk("R11", "refreshes before self-refresh", nref, 1);
      chk("R11", "self-refresh distance from refresh", cyc - tref, T_RC);
      repeat (3) @(negedge clk);
      sr_req_i = 1'b0;
      @(negedge clk);
      base = cyc;
      wait_release();
   endtask

   task automatic t_power_down();
      int bad;
      repeat (2) @(negedge clk);
      pd_req_i = 1'b1;
      @(negedge clk);
      chk("R9", "power-down entry", int'({cke_o, cmd_bits(), busy_o}), int'({1'b0, 4'b0111, 1'b1}));
      bad = 0;
      repeat (10) begin
         @(negedge clk);
         if (cke_o || !is_nop()) bad++;
      end
      chk("R9", "power-down hold violations", bad, 0);
      pd_req_i = 1'b0;
      @(negedge clk);
      chk("R9", "exit cycle", int'({cke_o, cmd_bits(), busy_o}), int'({1'b1, 4'b0111, 1'b1}));
      @(negedge clk);
      chk("R9", "bus released after exit", int'(busy_o), 0);
   endtask

   task automatic t_pd_forced();
      pd_req_i = 1'b1;
      @(negedge clk);
      while (!cke_o) @(negedge clk);
      while (cke_o) @(negedge clk);
      while (!cke_o) @(negedge clk);
      chk("R10", "forced exit phase", phase(), 1);
      while (!is_ref()) @(negedge clk);
      chk("R10", "refresh phase after forced exit", phase(), 4);
      pd_req_i = 1'b0;
      @(negedge clk);
      wait_release();
   endtask

   initial begin
      t_reset();
      t_first_refresh();
      t_postpone();
      t_self_refresh();
      t_priority();
      t_power_down();
      t_pd_forced();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule